// File: doc/BRIEF.md
# Programmable CPU Address-Window Decoder

This block holds a bank of address windows that software programs through a 32-bit register port. Each window maps a span of the 36-bit physical address space onto a fabric target, named by a 4-bit target number and an 8-bit attribute byte. When the CPU presents an address, every enabled window compares it against its own base. One clock later the block returns the target and attribute of the winning window, together with the address to forward. For a window that can translate, that address is the remapped one. An address that no window claims raises a miss.

A window's size must be a power of two of at least 64 KB, and its base must be aligned to that size. The size is stored as size minus one, in units of 64 KB, so it works directly as a mask over address bits 31:16. Only the first `NUM_REMAP` windows have remap registers. The other windows forward the address unchanged.

Register layout, by byte offset:
- Windows 0 to 7 each take a 16-byte slot at offset 16·w. The slot holds control at +0, base at +4, remap-low at +8 and remap-high at +12.
- Offsets 0x80 to 0x8F are unused.
- Window 8 and above each take an 8-byte slot at 0x90 + 8·(w−8), with control at +0 and base at +4.

Top module: `addr_window_decoder`

## Requirements
- R1: After a synchronous reset, every register reads 0 and every window is disabled. The outputs `dec_valid`, `dec_hit`, `dec_miss` and `multi_hit` are 0.
- R2: Control word fields:
  - bit 0 is the enable;
  - bits 7:4 are the target number reported on `dec_target`;
  - bits 15:8 are the attribute reported on `dec_attr`;
  - bits 31:16 are the window size minus one, in 64 KB units.
- R3: The base word holds address bits 31:16 in its bits 31:16 and address bits 35:32 in its bits 3:0. A window matches when every address bit above its size mask equals the base.
- R4: A window whose enable bit is 0 never matches, whatever its other fields hold.
- R5: A window with index below `NUM_REMAP` translates the address. The output is address bits 35:32 = remap-high bits 3:0, bits 31:16 = remap-low bits 31:16, and below that the remap bits are replaced by the address bits that fall inside the size mask.
- R6: A window with index at or above `NUM_REMAP` forwards the address unchanged. Its remap offsets read 0 and ignore writes.
- R7: The register layout above is decoded as stated. Writes to 0x80–0x8F, or to offsets past the last window, are ignored. Reads from those offsets return 0.
- R8: When several enabled windows match, the lowest-indexed one supplies the result. `multi_hit` is then set and stays set until reset.
- R9: A lookup with `cpu_valid` high produces its result in the next cycle, with `dec_valid` high and exactly one of `dec_hit` or `dec_miss` high.
  - On a miss, target and attribute are 0 and `dec_addr` equals the input address.
  - Without a lookup, all result outputs are 0.
  - A register write in the same cycle as a lookup affects only later lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset (bits 1:0 ignored) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| cpu_valid | input | 1 | Lookup request |
| cpu_addr | input | 36 | Physical address to decode |
| dec_valid | output | 1 | Registered: a lookup result is present |
| dec_hit | output | 1 | Registered: some window matched |
| dec_miss | output | 1 | Registered: no window matched |
| dec_target | output | 4 | Target number of the winning window |
| dec_attr | output | 8 | Attribute byte of the winning window |
| dec_addr | output | 36 | Translated or forwarded address |
| multi_hit | output | 1 | Sticky flag: a lookup matched more than one window |

## Verification
The assertions check on every cycle:
- the one-cycle timing of results;
- that hit and miss exclude each other;
- the clean target and attribute on a miss;
- that `multi_hit` stays set;
- the zero read-back from the unused hole.

Only the bench scenarios can show the rest, because each needs a programmed window set and a known address to give an expected value:
- which window wins;
- that the size mask and the 36-bit base compare are correct;
- remap arithmetic on the remap-capable windows and pass-through on the others;
- that writes to a disabled window, a hole offset or a missing offset change nothing.

// File: rtl/adec_pkg.sv
package adec_pkg;

    localparam int PA_W        = 36;   // physical address width
    localparam int RW          = 32;   // register width
    localparam int HI_W        = PA_W - RW;
    localparam int OFF_W       = 8;    // register offset width
    localparam int WIX_W       = 5;    // window index width
    localparam int GRAN        = 16;   // 64 KB granule
    localparam int WIDE_SLOTS  = 8;    // windows with 16-byte slots
    localparam logic [OFF_W-1:0] HOLE_LO     = 8'h80;
    localparam logic [OFF_W-1:0] NARROW_BASE = 8'h90;

    typedef enum logic [1:0] {FLD_CTRL, FLD_BASE, FLD_RLO, FLD_RHI} fld_e;

    typedef struct packed {
        logic              valid;
        logic [WIX_W-1:0]  win;
        fld_e              fld;
    } reg_sel_t;

    typedef struct packed {
        logic [7:0] attr;
        logic [3:0] target;
    } win_tag_t;

    typedef struct packed {
        logic            hit;
        logic            miss;
        win_tag_t        tag;
        logic [PA_W-1:0] addr;
    } dec_res_t;

    function automatic reg_sel_t decode_offset(input logic [OFF_W-1:0] off, input int num_win);
        reg_sel_t        s;
        logic [OFF_W-1:0] rel;
        s.valid = 1'b0;
        s.win   = '0;
        s.fld   = FLD_CTRL;
        rel     = off - NARROW_BASE;
        if (off < HOLE_LO) begin
            s.valid = 1'b1;
            s.win   = WIX_W'(off[6:4]);
            s.fld   = fld_e'(off[3:2]);
        end else if (off >= NARROW_BASE) begin
            s.valid = 1'b1;
            s.win   = WIX_W'(rel[OFF_W-1:3]) + WIX_W'(WIDE_SLOTS);
            s.fld   = off[2] ? FLD_BASE : FLD_CTRL;
        end
        if (int'(s.win) >= num_win) s.valid = 1'b0;
        return s;
    endfunction

    function automatic logic [PA_W-1:0] size_mask(input logic [RW-1:0] ctrl);
        return {{HI_W{1'b0}}, ctrl[RW-1:GRAN], {GRAN{1'b1}}};
    endfunction

    function automatic logic [PA_W-1:0] base_of(input logic [RW-1:0] b);
        return {b[HI_W-1:0], b[RW-1:GRAN], {GRAN{1'b0}}};
    endfunction

endpackage

// File: rtl/adec_regfile.sv
module adec_regfile
    import adec_pkg::*;
#(
    parameter int NUM_WIN   = 20,
    parameter int NUM_REMAP = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   reg_we,
    input  logic [OFF_W-1:0]       reg_addr,
    input  logic [RW-1:0]          reg_wdata,
    output logic [RW-1:0]          reg_rdata,
    output logic [RW-1:0]          ctrl_q     [NUM_WIN],
    output logic [RW-1:0]          base_q     [NUM_WIN],
    output logic [PA_W-1:0]        remap_base [NUM_WIN]
);
    localparam int RM_N = (NUM_REMAP > 0) ? NUM_REMAP : 1;

    reg_sel_t      sel;
    logic [RW-1:0] rlo_q [RM_N];
    logic [RW-1:0] rhi_q [RM_N];

    assign sel = decode_offset(reg_addr, NUM_WIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < NUM_WIN; w++) begin
                ctrl_q[w] <= '0;
                base_q[w] <= '0;
            end
        end else if (reg_we && sel.valid) begin
            for (int w = 0; w < NUM_WIN; w++) begin
                if (sel.win == WIX_W'(w)) begin
                    if (sel.fld == FLD_CTRL) ctrl_q[w] <= reg_wdata;
                    if (sel.fld == FLD_BASE) base_q[w] <= reg_wdata;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < RM_N; w++) begin
                rlo_q[w] <= '0;
                rhi_q[w] <= '0;
            end
        end else if (reg_we && sel.valid) begin
            for (int w = 0; w < RM_N; w++) begin
                if (w < NUM_REMAP && sel.win == WIX_W'(w)) begin
                    if (sel.fld == FLD_RLO) rlo_q[w] <= reg_wdata;
                    if (sel.fld == FLD_RHI) rhi_q[w] <= reg_wdata;
                end
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (sel.valid) begin
            for (int w = 0; w < NUM_WIN; w++) begin
                if (sel.win == WIX_W'(w)) begin
                    if (sel.fld == FLD_CTRL) reg_rdata = ctrl_q[w];
                    if (sel.fld == FLD_BASE) reg_rdata = base_q[w];
                end
            end
            for (int w = 0; w < RM_N; w++) begin
                if (w < NUM_REMAP && sel.win == WIX_W'(w)) begin
                    if (sel.fld == FLD_RLO) reg_rdata = rlo_q[w];
                    if (sel.fld == FLD_RHI) reg_rdata = rhi_q[w];
                end
            end
        end
    end

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_remap
        if (w < NUM_REMAP) begin : g_on
            assign remap_base[w] = {rhi_q[w][HI_W-1:0], rlo_q[w][RW-1:GRAN], {GRAN{1'b0}}};
        end else begin : g_off
            assign remap_base[w] = '0;
        end
    end

endmodule

// File: rtl/adec_window_match.sv
module adec_window_match
    import adec_pkg::*;
#(
    parameter bit REMAP_EN = 1'b1
) (
    input  logic [PA_W-1:0] cpu_addr,
    input  logic [RW-1:0]   ctrl,
    input  logic [RW-1:0]   base,
    input  logic [PA_W-1:0] remap,
    output logic            hit,
    output logic [PA_W-1:0] xaddr
);
    logic [PA_W-1:0] mask;
    logic            unused_fields;

    assign mask          = size_mask(ctrl);
    assign hit           = ctrl[0] && ((cpu_addr & ~mask) == (base_of(base) & ~mask));
    assign unused_fields = ^{ctrl[15:1], remap[GRAN-1:0]};

    if (REMAP_EN) begin : g_xlat
        assign xaddr = (remap & ~mask) | (cpu_addr & mask);
    end else begin : g_pass
        logic unused_remap;
        assign unused_remap = ^remap;
        assign xaddr        = cpu_addr;
    end

endmodule

// File: rtl/adec_pick.sv
module adec_pick
    import adec_pkg::*;
#(
    parameter int NUM_WIN = 20
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cpu_valid,
    input  logic [PA_W-1:0]     cpu_addr,
    input  logic [NUM_WIN-1:0]  hit_vec,
    input  logic [PA_W-1:0]     xaddr [NUM_WIN],
    input  win_tag_t            tags  [NUM_WIN],
    output logic                dec_valid,
    output dec_res_t            res_q,
    output logic                multi_hit
);
    localparam int SEL_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

    logic             found;
    logic [SEL_W-1:0] win_sel;
    dec_res_t         res_d;

    always_comb begin
        found   = 1'b0;
        win_sel = '0;
        for (int w = NUM_WIN - 1; w >= 0; w--) begin
            if (hit_vec[w]) begin
                found   = 1'b1;
                win_sel = SEL_W'(w);
            end
        end
    end

    always_comb begin
        res_d = '0;
        if (cpu_valid) begin
            res_d.hit  = found;
            res_d.miss = !found;
            res_d.addr = found ? xaddr[win_sel] : cpu_addr;
            res_d.tag  = found ? tags[win_sel] : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid <= 1'b0;
            res_q     <= '0;
            multi_hit <= 1'b0;
        end else begin
            dec_valid <= cpu_valid;
            res_q     <= res_d;
            if (cpu_valid && ($countones(hit_vec) > 1)) multi_hit <= 1'b1;
        end
    end

endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
    import adec_pkg::*;
#(
    parameter int NUM_WIN   = 20,
    parameter int NUM_REMAP = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        cpu_valid,
    input  logic [35:0] cpu_addr,
    output logic        dec_valid,
    output logic        dec_hit,
    output logic        dec_miss,
    output logic [3:0]  dec_target,
    output logic [7:0]  dec_attr,
    output logic [35:0] dec_addr,
    output logic        multi_hit
);
    logic [RW-1:0]      ctrl_q     [NUM_WIN];
    logic [RW-1:0]      base_q     [NUM_WIN];
    logic [PA_W-1:0]    remap_base [NUM_WIN];
    logic [PA_W-1:0]    xaddr      [NUM_WIN];
    win_tag_t           tags       [NUM_WIN];
    logic [NUM_WIN-1:0] hit_vec;
    dec_res_t           res_q;

    adec_regfile #(.NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .ctrl_q     (ctrl_q),
        .base_q     (base_q),
        .remap_base (remap_base)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        assign tags[w] = ctrl_q[w][15:4];
        adec_window_match #(.REMAP_EN(w < NUM_REMAP)) u_match (
            .cpu_addr (cpu_addr),
            .ctrl     (ctrl_q[w]),
            .base     (base_q[w]),
            .remap    (remap_base[w]),
            .hit      (hit_vec[w]),
            .xaddr    (xaddr[w])
        );
    end

    adec_pick #(.NUM_WIN(NUM_WIN)) u_pick (
        .clk       (clk),
        .rst       (rst),
        .cpu_valid (cpu_valid),
        .cpu_addr  (cpu_addr),
        .hit_vec   (hit_vec),
        .xaddr     (xaddr),
        .tags      (tags),
        .dec_valid (dec_valid),
        .res_q     (res_q),
        .multi_hit (multi_hit)
    );

    assign dec_hit    = res_q.hit;
    assign dec_miss   = res_q.miss;
    assign dec_target = res_q.tag.target;
    assign dec_attr   = res_q.tag.attr;
    assign dec_addr   = res_q.addr;

endmodule

// File: rtl/adec_checker.sv
module adec_checker (
    input logic        clk,
    input logic        rst,
    input logic [7:0]  reg_addr,
    input logic [31:0] reg_rdata,
    input logic        cpu_valid,
    input logic        dec_valid,
    input logic        dec_hit,
    input logic        dec_miss,
    input logic [3:0]  dec_target,
    input logic [7:0]  dec_attr,
    input logic        multi_hit
);
    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        rst_d |-> (!dec_valid && !multi_hit));

    p_hole_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (reg_addr[7:4] == 4'h8) |-> (reg_rdata == 32'h0));

    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        multi_hit |=> multi_hit);

    p_multi_cause_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(multi_hit) |-> $past(cpu_valid));

    p_valid_next_r9: assert property (@(posedge clk) disable iff (rst)
        cpu_valid |=> dec_valid);

    p_idle_next_r9: assert property (@(posedge clk) disable iff (rst)
        !cpu_valid |=> !dec_valid);

    p_hit_xor_miss_r9: assert property (@(posedge clk) disable iff (rst)
        dec_valid == (dec_hit ^ dec_miss));

    p_miss_clean_r9: assert property (@(posedge clk) disable iff (rst)
        dec_miss |-> (dec_target == 4'h0 && dec_attr == 8'h0));

endmodule

bind addr_window_decoder adec_checker u_adec_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .cpu_valid  (cpu_valid),
    .dec_valid  (dec_valid),
    .dec_hit    (dec_hit),
    .dec_miss   (dec_miss),
    .dec_target (dec_target),
    .dec_attr   (dec_attr),
    .multi_hit  (multi_hit)
);

// File: tb/test_addr_window_decoder.sv
module test_addr_window_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int NW         = 20;
    localparam int NR         = 6;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        cpu_valid = 1'b0;
    logic [35:0] cpu_addr = 36'h0;
    logic        dec_valid, dec_hit, dec_miss, multi_hit;
    logic [3:0]  dec_target;
    logic [7:0]  dec_attr;
    logic [35:0] dec_addr;

    addr_window_decoder #(.NUM_WIN(NW), .NUM_REMAP(NR)) i_addr_window_decoder (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_valid(cpu_valid),
        .cpu_addr(cpu_addr), .dec_valid(dec_valid), .dec_hit(dec_hit),
        .dec_miss(dec_miss), .dec_target(dec_target), .dec_attr(dec_attr),
        .dec_addr(dec_addr), .multi_hit(multi_hit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_chk  = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    string exp_req = "R1";
    bit    started = 0;
    bit    done    = 0;

    logic [31:0] m_ctrl [NW];
    logic [31:0] m_base [NW];
    logic [31:0] m_rlo  [NW];
    logic [31:0] m_rhi  [NW];

    logic        e_valid, e_hit, e_miss, e_multi;
    logic [3:0]  e_tgt;
    logic [7:0]  e_attr;
    logic [35:0] e_addr;

    function automatic bit locate(input int off, output int win, output int fld);
        win = 0; fld = 0;
        if (off < 128) begin
            win = off / 16; fld = (off % 16) / 4;
        end else if (off < 144) begin
            return 0;
        end else begin
            win = 8 + (off - 144) / 8; fld = ((off - 144) % 8) / 4;
        end
        if (win >= NW) return 0;
        if (fld >= 2 && win >= NR) return 0;
        return 1;
    endfunction

    function automatic logic [31:0] m_read(input int off);
        int win, fld;
        if (!locate(off, win, fld)) return 32'h0;
        case (fld)
            0: return m_ctrl[win];
            1: return m_base[win];
            2: return m_rlo[win];
            default: return m_rhi[win];
        endcase
    endfunction

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // reference model, advanced on every rising edge
    always @(posedge clk) begin
        logic [63:0] a, b, sz, r;
        int first, cnt, win, fld;
        started = 1;
        exp_req = cur_req;
        if (rst) begin
            for (int w = 0; w < NW; w++) begin
                m_ctrl[w] = 0; m_base[w] = 0; m_rlo[w] = 0; m_rhi[w] = 0;
            end
            e_valid = 0; e_hit = 0; e_miss = 0; e_multi = 0;
            e_tgt = 0; e_attr = 0; e_addr = 0;
        end else begin
            e_valid = cpu_valid; e_hit = 0; e_miss = 0;
            e_tgt = 0; e_attr = 0; e_addr = 0;
            if (cpu_valid) begin
                a = {28'h0, cpu_addr};
                first = -1; cnt = 0;
                for (int w = 0; w < NW; w++) begin
                    b  = {28'h0, m_base[w][3:0], m_base[w][31:16], 16'h0};
                    sz = ({48'h0, m_ctrl[w][31:16]} + 64'd1) << 16;
                    if (m_ctrl[w][0] && a >= b && a < b + sz) begin
                        cnt++;
                        if (first < 0) first = w;
                    end
                end
                if (cnt > 1) e_multi = 1;
                if (first >= 0) begin
                    e_hit  = 1;
                    e_tgt  = m_ctrl[first][7:4];
                    e_attr = m_ctrl[first][15:8];
                    b = {28'h0, m_base[first][3:0], m_base[first][31:16], 16'h0};
                    if (first < NR) begin
                        r = {28'h0, m_rhi[first][3:0], m_rlo[first][31:16], 16'h0};
                        e_addr = 36'(a - b + r);
                    end else begin
                        e_addr = cpu_addr;
                    end
                end else begin
                    e_miss = 1;
                    e_addr = cpu_addr;
                end
            end
            if (reg_we && locate(int'(reg_addr), win, fld)) begin
                case (fld)
                    0: m_ctrl[win] = reg_wdata;
                    1: m_base[win] = reg_wdata;
                    2: m_rlo[win]  = reg_wdata;
                    default: m_rhi[win] = reg_wdata;
                endcase
            end
        end
    end

    // output comparison on every falling edge
    always @(negedge clk) begin
        if (started && !done) begin
            chk("dec_valid",  {63'h0, dec_valid}, {63'h0, e_valid}, exp_req);
            chk("dec_hit",    {63'h0, dec_hit},   {63'h0, e_hit},   exp_req);
            chk("dec_miss",   {63'h0, dec_miss},  {63'h0, e_miss},  exp_req);
            chk("dec_target", {60'h0, dec_target}, {60'h0, e_tgt},  exp_req);
            chk("dec_attr",   {56'h0, dec_attr},  {56'h0, e_attr},  exp_req);
            chk("dec_addr",   {28'h0, dec_addr},  {28'h0, e_addr},  exp_req);
            chk("multi_hit",  {63'h0, multi_hit}, {63'h0, e_multi}, exp_req);
        end
    end

    task automatic wr(input logic [7:0] off, input logic [31:0] d);
        reg_we = 1; reg_addr = off; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd(input logic [7:0] off);
        reg_addr = off;
        #1;
        chk($sformatf("rdata@%02h", off), {32'h0, reg_rdata}, {32'h0, m_read(int'(off))}, cur_req);
        @(negedge clk);
    endtask

    task automatic rd_val(input logic [7:0] off, input logic [31:0] v);
        reg_addr = off;
        #1;
        chk($sformatf("rdata@%02h", off), {32'h0, reg_rdata}, {32'h0, v}, cur_req);
        @(negedge clk);
    endtask

    task automatic look(input logic [35:0] a);
        cpu_valid = 1; cpu_addr = a;
        @(negedge clk);
        cpu_valid = 0;
    endtask

    task automatic wr_look(input logic [7:0] off, input logic [31:0] d, input logic [35:0] a);
        reg_we = 1; reg_addr = off; reg_wdata = d;
        cpu_valid = 1; cpu_addr = a;
        @(negedge clk);
        reg_we = 0; cpu_valid = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R9 watchdog: actual %0d cycles expected completion", WATCHDOG);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: reset state
        cur_req = "R1";
        rd_val(8'h00, 0); rd_val(8'h24, 0); rd_val(8'h90, 0); rd_val(8'hEC, 0);
        look(36'h0_F100_0000);

        // R2/R5: window 0, 1 MB, target 4, attr E0, remapped to 0x2000_0000
        cur_req = "R2";
        wr(8'h00, 32'h000F_E041);
        wr(8'h04, 32'hF100_0000);
        wr(8'h08, 32'h2000_0000);
        rd_val(8'h00, 32'h000F_E041);
        look(36'h0_F101_2345);
        cur_req = "R3";
        look(36'h0_F110_0000);
        look(36'h1_F100_0000);

        // R3/R6: window 9, 64 KB at 0x3_ABCD_0000, no remap
        cur_req = "R3";
        wr(8'h98, 32'h0000_2F11);
        wr(8'h9C, 32'hABCD_0003);
        rd_val(8'h9C, 32'hABCD_0003);
        look(36'h3_ABCD_1234);
        look(36'h0_ABCD_1234);
        look(36'h3_ABCE_0000);

        // R4: enable cleared, other fields kept
        cur_req = "R4";
        wr(8'h98, 32'h0000_2F10);
        look(36'h3_ABCD_1234);
        rd_val(8'h98, 32'h0000_2F10);

        // R5: window 2, 16 MB, remap with high bits
        cur_req = "R5";
        wr(8'h20, 32'h00FF_D081);
        wr(8'h24, 32'hD000_0000);
        wr(8'h28, 32'h4500_0000);
        wr(8'h2C, 32'h0000_0002);
        rd_val(8'h2C, 32'h0000_0002);
        look(36'h0_D0AB_CDEF);
        look(36'h0_D000_0000);

        // R6: window 6 lies beyond NUM_REMAP
        cur_req = "R6";
        wr(8'h68, 32'h1234_0000);
        wr(8'h6C, 32'h0000_0005);
        rd_val(8'h68, 0); rd_val(8'h6C, 0);
        wr(8'h60, 32'h0000_3E11);
        wr(8'h64, 32'h8000_0000);
        look(36'h0_8000_1111);

        // R7: hole, out-of-range offsets, narrow slots
        cur_req = "R7";
        for (int k = 0; k < 4; k++) wr(8'h80 + 8'(4 * k), 32'hFFFF_FFFF);
        for (int k = 0; k < 4; k++) rd_val(8'h80 + 8'(4 * k), 0);
        rd_val(8'h70, 0); rd_val(8'h90, 0); rd_val(8'h7C, 0);
        wr(8'hF0, 32'hFFFF_FFFF); wr(8'hF4, 32'hFFFF_FFFF);
        rd_val(8'hF0, 0); rd_val(8'hF4, 0);
        wr(8'hE8, 32'h0003_70C1);
        wr(8'hEC, 32'h6004_0000);
        rd_val(8'hE8, 32'h0003_70C1); rd_val(8'hEC, 32'h6004_0000);
        rd_val(8'hE0, 0);
        look(36'h0_6006_0001);
        wr(8'h90, 32'h0000_0171);
        rd_val(8'h90, 32'h0000_0171); rd(8'h94);
        look(36'h0_0000_0010);

        // R8: overlap, lowest index wins, sticky flag
        cur_req = "R8";
        look(36'h0_F100_0010);
        wr(8'h30, 32'h0000_013D);
        wr(8'h34, 32'hF100_0000);
        look(36'h0_F100_0010);
        look(36'h0_D000_0004);
        look(36'h0_F108_0000);

        // R9: back-to-back lookups and write/lookup in the same cycle
        cur_req = "R9";
        cpu_valid = 1; cpu_addr = 36'h0_F100_0004; @(negedge clk);
        cpu_addr = 36'h0_1234_5678; @(negedge clk);
        cpu_addr = 36'h2_0000_0000; @(negedge clk);
        cpu_valid = 0;
        wr(8'h44, 32'h5000_0000);
        wr_look(8'h40, 32'h0000_A051, 36'h0_5000_0000);
        look(36'h0_5000_0000);
        @(negedge clk);

        // R1: reset again mid-run
        cur_req = "R1";
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        rd_val(8'h00, 0); rd_val(8'h28, 0); rd_val(8'hE8, 0);
        look(36'h0_F100_0010);
        @(negedge clk);

        finish_run();
    end

endmodule